// File: doc/BRIEF.md
# 64-bit Interval Timer with Atomic Count Readout

This block is a memory-mapped interval timer. A 64-bit count, twice the width of the register port, advances once for every p+1 source ticks, where p is a 4-bit divide value held in the mode register. The source tick is either every cycle of the block clock or a tick-enable strobe that arrives from outside the block, chosen by a mode bit. Software stops the timer, programs the mode and the period as two register halves, turns on the interrupt and then starts the count. When the count reaches the period, the timer raises a pending flag. In continuous mode it then wraps to zero and keeps counting. In one-shot mode it stops.

The count is read as two register halves. Reading the low half captures the high half in a holding register, so the pair always forms one coherent value, however long software waits before the second read. The pending flag clears when its register is read. A period event that lands in the same cycle as that read is kept. The interrupt output is the pending flag gated by its enable bit.

Top module: `interval_timer64`

## Requirements
- R1: After reset, irq is 0. The count, mode, period, enable and status registers read 0.
- R2: Writable fields read back what was written. The mode register at 0x04 holds bit 0 (continuous), bit 3 (external source) and bits 11:8 (divide value); all other mode bits read 0. Period low is at 0x08 and period high at 0x0C. The interrupt enable is bit 0 of 0x10. The control register at 0x00 and every unmapped offset read 0.
- R3: Writing 1 to bit 0 of 0x00 (go) sets the count to 0 and starts it. While running, each divided tick raises the count by one.
- R4: With divide value p, the count advances once per p+1 source ticks.
- R5: With mode bit 3 clear, every clock cycle is a source tick. With it set, only cycles with alt_tick_i high are source ticks.
- R6: In continuous mode (mode bit 0 = 1), a divided tick that finds the count equal to the period sets the pending flag, returns the count to 0 and keeps the timer running.
- R7: In one-shot mode (mode bit 0 = 0), the same event sets the pending flag, holds the count at the period and stops the timer.
- R8: Writing 1 to bit 8 of 0x00 (halt) stops the timer, clears the count and clears the pending flag. Halt wins over go when both are written together.
- R9: A read of the count low half at 0x20 captures the high half. Later reads of 0x24 return that captured value until the next low-half read.
- R10: A read of 0x1C returns the pending flag in bit 0 and then clears it. A period event in the same cycle as that read leaves the flag set.
- R11: irq equals the pending flag ANDed with enable bit 0 at 0x10.
- R12: Writes to 0x1C, 0x20 and 0x24 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alt_tick_i | input | 1 | Source tick-enable used when the external source is selected |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status and captures the count's high half) |
| addr | input | 6 | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from addr |
| irq | output | 1 | Period interrupt |

## Verification
The assertions assume that a read and a write never fall in the same cycle. They also assume that the read strobe lasts one cycle for each access, because each strobe cycle clears the status and captures the count's high half. The bench drives each access as a single-cycle strobe and never overlaps a read with a write. It drives alt_tick_i only as isolated one-cycle pulses, so that every source tick can be counted exactly. The bench runs with a 16-bit register port. With that width, the free-running count crosses into its upper half within the run.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   localparam int ADDR_W = 6;
   typedef logic [ADDR_W-1:0] reg_addr_t;

   localparam reg_addr_t OFS_CTRL   = 6'h00;
   localparam reg_addr_t OFS_MODE   = 6'h04;
   localparam reg_addr_t OFS_PER_LO = 6'h08;
   localparam reg_addr_t OFS_PER_HI = 6'h0C;
   localparam reg_addr_t OFS_IEN    = 6'h10;
   localparam reg_addr_t OFS_STS    = 6'h1C;
   localparam reg_addr_t OFS_CNT_LO = 6'h20;
   localparam reg_addr_t OFS_CNT_HI = 6'h24;

   localparam int CTRL_GO       = 0;
   localparam int CTRL_HALT     = 8;
   localparam int MODE_CONT     = 0;
   localparam int MODE_ALT      = 3;
   localparam int MODE_PRES_LSB = 8;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
   import itmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PRES_W = 4,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  reg_addr_t         addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              evt,
   output logic              go_o,
   output logic              halt_o,
   output logic              cont_o,
   output logic              alt_o,
   output logic [PRES_W-1:0] pres_o,
   output logic [CNT_W-1:0]  period_o,
   output logic              sts_o,
   output logic [DATA_W-1:0] hi_snap_o,
   output logic              irq_o
);
   logic              cont_q, alt_q, ien_q, sts_q;
   logic [PRES_W-1:0] pres_q;
   logic [DATA_W-1:0] per_lo_q, per_hi_q, hi_snap_q;

   logic wr_ctrl, rd_sts, rd_lo;
   assign wr_ctrl = wr_en && (addr == OFS_CTRL);
   assign rd_sts  = rd_en && (addr == OFS_STS);
   assign rd_lo   = rd_en && (addr == OFS_CNT_LO);

   assign go_o   = wr_ctrl && wdata[CTRL_GO];
   assign halt_o = wr_ctrl && wdata[CTRL_HALT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cont_q   <= 1'b0;
         alt_q    <= 1'b0;
         pres_q   <= '0;
         per_lo_q <= '0;
         per_hi_q <= '0;
         ien_q    <= 1'b0;
      end else if (wr_en) begin
         case (addr)
            OFS_MODE: begin
               cont_q <= wdata[MODE_CONT];
               alt_q  <= wdata[MODE_ALT];
               pres_q <= wdata[MODE_PRES_LSB +: PRES_W];
            end
            OFS_PER_LO: per_lo_q <= wdata;
            OFS_PER_HI: per_hi_q <= wdata;
            OFS_IEN:    ien_q    <= wdata[0];
            default: ;
         endcase
      end
   end

   // pending flag: halt clears, a new event beats a clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts_q <= 1'b0;
      else if (halt_o) sts_q <= 1'b0;
      else if (evt)    sts_q <= 1'b1;
      else if (rd_sts) sts_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_snap_q <= '0;
      else if (rd_lo) hi_snap_q <= count[CNT_W-1:DATA_W];
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_MODE: begin
            rdata[MODE_CONT]                = cont_q;
            rdata[MODE_ALT]                 = alt_q;
            rdata[MODE_PRES_LSB +: PRES_W]  = pres_q;
         end
         OFS_PER_LO: rdata    = per_lo_q;
         OFS_PER_HI: rdata    = per_hi_q;
         OFS_IEN:    rdata[0] = ien_q;
         OFS_STS:    rdata[0] = sts_q;
         OFS_CNT_LO: rdata    = count[DATA_W-1:0];
         OFS_CNT_HI: rdata    = hi_snap_q;
         default: ;
      endcase
   end

   assign cont_o    = cont_q;
   assign alt_o     = alt_q;
   assign pres_o    = pres_q;
   assign period_o  = {per_hi_q, per_lo_q};
   assign sts_o     = sts_q;
   assign hi_snap_o = hi_snap_q;
   assign irq_o     = sts_q & ien_q;
endmodule

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
   parameter int PRES_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic              src_tick,
   input  logic [PRES_W-1:0] pres,
   output logic              tick_o
);
   logic [PRES_W-1:0] div_q;
   logic              wrap;

   assign wrap   = (div_q == pres);
   assign tick_o = run && src_tick && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_q <= '0;
      else if (restart)          div_q <= '0;
      else if (run && src_tick)  div_q <= wrap ? '0 : div_q + 1'b1;
   end
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             halt,
   input  logic             tick,
   input  logic             cont,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count_o,
   output logic             run_o,
   output logic             evt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q, at_end;

   assign at_end = (cnt_q == period);
   assign evt_o  = tick && at_end && !go && !halt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (halt) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (go) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (tick) begin
         if (!at_end)   cnt_q <= cnt_q + 1'b1;
         else if (cont) cnt_q <= '0;
         else           run_q <= 1'b0;
      end
   end

   assign count_o = cnt_q;
   assign run_o   = run_q;
endmodule

// File: rtl/interval_timer64.sv
module interval_timer64
   import itmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PRES_W = 4,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alt_tick_i,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [5:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   if (PRES_W < 1 || PRES_W > 4) begin : g_bad_pres
      $error("interval_timer64: PRES_W must lie in 1..4");
   end
   if (DATA_W < MODE_PRES_LSB + PRES_W) begin : g_bad_width
      $error("interval_timer64: DATA_W too narrow for the mode fields");
   end

   logic              go, halt, cont_mode, alt_mode, src_tick, tick, evt, running, sts_q;
   logic [PRES_W-1:0] pres;
   logic [CNT_W-1:0]  period, count_q;
   logic [DATA_W-1:0] hi_snap;

   assign src_tick = alt_mode ? alt_tick_i : 1'b1;

   itmr_regs #(.DATA_W(DATA_W), .PRES_W(PRES_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .count(count_q), .evt(evt),
      .go_o(go), .halt_o(halt), .cont_o(cont_mode), .alt_o(alt_mode),
      .pres_o(pres), .period_o(period), .sts_o(sts_q), .hi_snap_o(hi_snap),
      .irq_o(irq)
   );

   itmr_prescale #(.PRES_W(PRES_W)) u_pres (
      .clk(clk), .rst_n(rst_n), .run(running), .restart(go | halt),
      .src_tick(src_tick), .pres(pres), .tick_o(tick)
   );

   itmr_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .go(go), .halt(halt), .tick(tick),
      .cont(cont_mode), .period(period), .count_o(count_q),
      .run_o(running), .evt_o(evt)
   );
endmodule

// File: rtl/itmr_check.sv
module itmr_check
   import itmr_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int CNT_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [5:0]        addr,
   input logic              go,
   input logic              halt,
   input logic              irq,
   input logic              evt,
   input logic              running,
   input logic              cont_mode,
   input logic              sts_q,
   input logic [CNT_W-1:0]  count_q,
   input logic [DATA_W-1:0] hi_snap
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   a_r3_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
      go && !halt |=> running && count_q == '0);

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      running && $past(running) && count_q != '0 |->
         (count_q == $past(count_q) + ONE) || (count_q == $past(count_q)));

   a_r6_cont_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      evt && cont_mode |=> running && count_q == '0);

   a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      evt && !cont_mode |=> !running && $stable(count_q));

   a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !running && count_q == '0 && !sts_q && !irq);

   a_r9_snap: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == OFS_CNT_LO |=> hi_snap == $past(count_q[CNT_W-1:DATA_W]));

   a_r10_evt_kept: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> sts_q);

   a_r10_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == OFS_STS && !evt && !halt |=> !sts_q);

   a_r11_irq_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_q |-> !irq);
endmodule

bind interval_timer64 itmr_check #(.DATA_W(DATA_W)) u_check (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .go(go), .halt(halt),
   .irq(irq), .evt(evt), .running(running), .cont_mode(cont_mode),
   .sts_q(sts_q), .count_q(count_q), .hi_snap(hi_snap)
);

// File: tb/test_interval_timer64.sv
module test_interval_timer64;
   localparam int DW = 16;

   logic          clk = 1'b0, rst_n = 1'b0, alt_tick_i = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, irq;
   logic [5:0]    addr = '0;
   logic [DW-1:0] wdata = '0, rdata;

   int checks = 0, failures = 0;
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #10 clk = ~clk;

   interval_timer64 #(.DATA_W(DW)) i_interval_timer64 (
      .clk(clk), .rst_n(rst_n), .alt_tick_i(alt_tick_i), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // monitor: compares each read against the next scoreboard entry
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (rd_en) begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            automatic string         t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
               failures++;
               $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, got=timeout expected=done");
      finish_run();
   end

   task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [DW-1:0] e, input string t);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      alt_tick_i = 1'b1;
      @(negedge clk);
      alt_tick_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string t);
      checks++;
      if (irq !== e) begin
         failures++;
         $display("FAIL %s: irq=%b expected=%b", t, irq, e);
      end
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      rd(6'h20, 16'h0, "R1 count low");
      rd(6'h04, 16'h0, "R1 mode");
      rd(6'h08, 16'h0, "R1 period low");
      rd(6'h1C, 16'h0, "R1 status");
      // R2 readback and unmapped
      wr(6'h04, 16'hFFFF);
      rd(6'h04, 16'h0F09, "R2 mode fields");
      wr(6'h08, 16'h1234);
      wr(6'h0C, 16'hABCD);
      rd(6'h08, 16'h1234, "R2 period low");
      rd(6'h0C, 16'hABCD, "R2 period high");
      wr(6'h10, 16'hFFFF);
      rd(6'h10, 16'h0001, "R2 enable");
      rd(6'h00, 16'h0, "R2 control reads zero");
      rd(6'h14, 16'h0, "R2 unmapped 0x14");
      rd(6'h3C, 16'h0, "R2 unmapped 0x3C");
      wr(6'h10, 16'h0);
      // R3 R5 R9 free-running on the clock, all-ones period
      wr(6'h00, 16'h0100);
      wr(6'h04, 16'h0001);
      wr(6'h0C, 16'hFFFF);
      wr(6'h08, 16'hFFFF);
      wr(6'h00, 16'h0001);
      rd(6'h20, 16'h0001, "R3 R5 count one cycle after go");
      idle(65517);
      rd(6'h20, 16'hFFF0, "R3 count before crossing");
      idle(40);
      rd(6'h24, 16'h0000, "R9 captured high half holds");
      rd(6'h20, 16'h001C, "R9 count after crossing");
      rd(6'h24, 16'h0001, "R9 new capture");
      wr(6'h00, 16'h0100);
      rd(6'h20, 16'h0, "R8 halt clears count");
      // R6 R10 R11 R12 continuous on external ticks
      wr(6'h10, 16'h0001);
      wr(6'h04, 16'h0009);
      wr(6'h0C, 16'h0);
      wr(6'h08, 16'h0002);
      wr(6'h00, 16'h0001);
      tick(); tick();
      rd(6'h20, 16'h0002, "R5 R3 two external ticks");
      chk_irq(1'b0, "R6 no event before period");
      tick();
      chk_irq(1'b1, "R6 R11 event raises irq");
      rd(6'h20, 16'h0, "R6 continuous wrap");
      wr(6'h1C, 16'h0);
      chk_irq(1'b1, "R12 status write ignored");
      wr(6'h10, 16'h0);
      chk_irq(1'b0, "R11 enable off masks irq");
      wr(6'h10, 16'h0001);
      chk_irq(1'b1, "R11 enable on shows pending");
      rd(6'h1C, 16'h0001, "R10 status pending");
      chk_irq(1'b0, "R10 read cleared");
      rd(6'h1C, 16'h0, "R10 status cleared");
      tick();
      idle(10);
      rd(6'h20, 16'h0001, "R5 no advance without alt tick");
      wr(6'h20, 16'h0055);
      wr(6'h24, 16'h0007);
      rd(6'h20, 16'h0001, "R12 count write ignored");
      rd(6'h24, 16'h0, "R12 high half write ignored");
      tick();
      // R10 read coinciding with an event
      @(negedge clk);
      alt_tick_i = 1'b1; rd_en = 1'b1; addr = 6'h1C;
      exp_q.push_back(16'h0); tag_q.push_back("R10 read at event returns old");
      @(negedge clk);
      alt_tick_i = 1'b0; rd_en = 1'b0;
      chk_irq(1'b1, "R10 coincident event kept");
      rd(6'h1C, 16'h0001, "R10 coincident event pending");
      // R4 divide by three
      wr(6'h00, 16'h0100);
      wr(6'h04, 16'h0209);
      wr(6'h08, 16'h00FF);
      wr(6'h00, 16'h0001);
      tick(); tick();
      rd(6'h20, 16'h0, "R4 two ticks with p=2");
      tick();
      rd(6'h20, 16'h0001, "R4 third tick advances");
      tick(); tick(); tick();
      rd(6'h20, 16'h0002, "R4 sixth tick advances");
      // R7 one-shot
      wr(6'h00, 16'h0100);
      wr(6'h04, 16'h0008);
      wr(6'h08, 16'h0001);
      wr(6'h00, 16'h0001);
      tick();
      chk_irq(1'b0, "R7 before period");
      tick();
      chk_irq(1'b1, "R7 event");
      rd(6'h20, 16'h0001, "R7 holds at period");
      tick(); tick(); tick();
      rd(6'h20, 16'h0001, "R7 stopped");
      rd(6'h1C, 16'h0001, "R7 status set");
      // R8 halt beats go
      wr(6'h04, 16'h0009);
      wr(6'h08, 16'h0);
      wr(6'h00, 16'h0001);
      tick();
      chk_irq(1'b1, "R8 pending before halt");
      wr(6'h00, 16'h0101);
      chk_irq(1'b0, "R8 halt clears irq");
      rd(6'h1C, 16'h0, "R8 halt clears status");
      tick(); tick();
      rd(6'h20, 16'h0, "R8 halted timer does not count");
      idle(2);
      finish_run();
   end
endmodule